// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

The block keeps wall-clock time as a plain count of seconds. An input tick enable, normally pulsed at 32.768 kHz, feeds a programmable prescaler. The prescaler emits one pulse per second, and each pulse advances a 32-bit seconds register. A 32-bit alarm register is compared against that count. The prescaler has a divide field and a separate trim field, and the trim adds whole input ticks to every second to correct a slow or fast crystal.

A status/control register holds two sticky event flags, one for the alarm and one for the per-second tick. Each flag has an enable bit. Two separate interrupt lines come out of the block: one for the per-second tick and one for the alarm. Software accesses four registers through a single-cycle port. Writes take effect at the clock edge and read data is combinational from the selected register. The register index is 0 for seconds, 1 for alarm, 2 for status/control and 3 for prescaler.

Top module: `rtc_secs_alarm`

## Requirements
- R1: After reset the seconds and alarm registers read 0, status/control reads 0, the prescaler reads 32767 in bits 15:0 with trim 0, and both interrupt outputs are low.
- R2: With divide D in prescaler bits 15:0 and trim T in bits 23:16, the seconds register advances by one every D+T+1 cycles in which tick_en is high. Cycles with tick_en low do not count. A write to the prescaler restarts the count of input ticks from zero.
- R3: A write to index 0 loads the seconds register. When that write falls in the same cycle as a second boundary, the written value is kept and is not incremented.
- R4: Status bit 1, the tick pending flag, sets on every second boundary whether or not its enable is set.
- R5: Status bit 0, the alarm pending flag, sets one cycle after a compare event finds seconds equal to alarm. A compare event is an increment, a write to seconds or a write to alarm. While the two values stay equal and no new compare event occurs, a cleared alarm flag stays clear.
- R6: Writing 1 to status bit 0 or bit 1 clears that pending flag. Writing 0 to it leaves the flag unchanged.
- R7: Status bit 2 is the alarm enable and bit 3 is the tick enable. Both are written directly by a status write and read back in place.
- R8: irq_alarm is high exactly while bits 0 and 2 are both 1. irq_hz is high exactly while bits 1 and 3 are both 1.
- R9: If a set event and a write-one-to-clear of the same pending flag happen in the same cycle, the flag ends up set.
- R10: The prescaler register reads back divide in bits 15:0 and an 8-bit trim in bits 23:16. The other bits read 0.
- R11: The seconds register increments modulo 2^32, so 0xFFFFFFFF advances to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One input tick of the oscillator time base per high cycle |
| bus_addr | input | 2 | Register index: 0 seconds, 1 alarm, 2 status/control, 3 prescaler |
| bus_we | input | 1 | Write strobe for the indexed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the indexed register |
| irq_hz | output | 1 | Per-second tick interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The bound checker watches several rules on every cycle. It checks the seconds register stepping by exactly one on a second boundary, holding otherwise, and taking a written value. It checks that the tick flag sets on every boundary, that a write-one clears it, and that the alarm flag cannot rise without a compare event in the previous cycle. It also checks that enables follow status writes and that no interrupt is raised without its enable. Only the bench scenarios show the absolute second period with and without trim, the restart of the prescaler phase, and single-shot alarm matches raised by counting and by register writes. The same applies to the same-cycle priority cases, the wrap from all ones to zero and the exact register read-back encodings.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
   typedef enum logic [1:0] {
      RA_SECS  = 2'd0,
      RA_ALARM = 2'd1,
      RA_STAT  = 2'd2,
      RA_PRESC = 2'd3
   } rtc_addr_e;

   // event channel indices inside the status register
   localparam int EV_ALARM = 0;
   localparam int EV_HZ    = 1;
   localparam int NUM_EV   = 2;
   // an enable bit sits this far above its pending bit
   localparam int EN_SHIFT = 2;
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
   parameter int DIV_W      = 16,
   parameter int TRIM_W     = 8,
   parameter bit TRIM_EN    = 1'b1,
   parameter int DIV_RESET  = 32767,
   parameter int TRIM_RESET = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              load,
   input  logic [DIV_W-1:0]  div_in,
   input  logic [TRIM_W-1:0] trim_in,
   output logic [DIV_W-1:0]  div_q,
   output logic [TRIM_W-1:0] trim_q,
   output logic              one_hz
);
   localparam int ACC_W = DIV_W + 1;

   logic [ACC_W-1:0] tick_cnt;
   logic [ACC_W-1:0] limit;
   logic             at_limit;

   always_ff @(posedge clk) begin
      if (!rst_n)    div_q <= DIV_W'(DIV_RESET);
      else if (load) div_q <= div_in;
   end

   generate
      if (TRIM_EN) begin : g_trim
         always_ff @(posedge clk) begin
            if (!rst_n)    trim_q <= TRIM_W'(TRIM_RESET);
            else if (load) trim_q <= trim_in;
         end
      end else begin : g_no_trim
         assign trim_q = '0;
      end
   endgenerate

   assign limit    = ACC_W'(div_q) + ACC_W'(trim_q);
   assign at_limit = (tick_cnt >= limit);
   assign one_hz   = tick_en && !load && at_limit;

   always_ff @(posedge clk) begin
      if (!rst_n)       tick_cnt <= '0;
      else if (load)    tick_cnt <= '0;
      else if (tick_en) tick_cnt <= at_limit ? '0 : tick_cnt + 1'b1;
   end
endmodule

// File: rtl/rtc_seconds.sv
`timescale 1ns/1ps
module rtc_seconds #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             one_hz,
   input  logic             wr_secs,
   input  logic             wr_alarm,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] secs_q,
   output logic [CNT_W-1:0] alarm_q,
   output logic             match_evt
);
   logic cmp_req;

   always_ff @(posedge clk) begin
      if (!rst_n)       secs_q <= '0;
      else if (wr_secs) secs_q <= wdata;
      else if (one_hz)  secs_q <= secs_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        alarm_q <= '0;
      else if (wr_alarm) alarm_q <= wdata;
   end

   // compare only once after each change of either operand
   always_ff @(posedge clk) begin
      if (!rst_n) cmp_req <= 1'b0;
      else        cmp_req <= one_hz | wr_secs | wr_alarm;
   end

   assign match_evt = cmp_req && (secs_q == alarm_q);
endmodule

// File: rtl/rtc_status.sv
`timescale 1ns/1ps
module rtc_status #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_evt,
   input  logic         wr_stat,
   input  logic [N-1:0] clr_bits,
   input  logic [N-1:0] en_bits,
   output logic [N-1:0] pend_q,
   output logic [N-1:0] en_q,
   output logic [N-1:0] irq
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_ch
         always_ff @(posedge clk) begin
            if (!rst_n)                      pend_q[i] <= 1'b0;
            else if (set_evt[i])             pend_q[i] <= 1'b1;
            else if (wr_stat && clr_bits[i]) pend_q[i] <= 1'b0;
         end

         always_ff @(posedge clk) begin
            if (!rst_n)       en_q[i] <= 1'b0;
            else if (wr_stat) en_q[i] <= en_bits[i];
         end

         assign irq[i] = pend_q[i] & en_q[i];
      end
   endgenerate
endmodule

// File: rtl/rtc_secs_alarm.sv
`timescale 1ns/1ps
module rtc_secs_alarm
   import rtc_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int DIV_W      = 16,
   parameter int TRIM_W     = 8,
   parameter int TRIM_LSB   = 16,
   parameter bit TRIM_EN    = 1'b1,
   parameter int DIV_RESET  = 32767,
   parameter int TRIM_RESET = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic [1:0]       bus_addr,
   input  logic             bus_we,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   output logic             irq_hz,
   output logic             irq_alarm
);
   generate
      if (TRIM_LSB < DIV_W) begin : g_err_overlap
         $error("trim field overlaps divide field");
      end
      if (TRIM_LSB + TRIM_W > CNT_W) begin : g_err_width
         $error("trim field exceeds register width");
      end
      if (TRIM_W > DIV_W) begin : g_err_trim
         $error("trim wider than divide");
      end
      if (CNT_W < NUM_EV + EN_SHIFT + NUM_EV) begin : g_err_stat
         $error("register too narrow for status bits");
      end
      if (DIV_RESET >= (1 << DIV_W)) begin : g_err_rst
         $error("divide reset value does not fit");
      end
   endgenerate

   logic              wr_secs, wr_alarm, wr_stat, wr_presc;
   logic              one_hz, match_evt;
   logic [DIV_W-1:0]  div_q;
   logic [TRIM_W-1:0] trim_q;
   logic [CNT_W-1:0]  secs_q, alarm_q;
   logic [NUM_EV-1:0] set_evt, pend_q, en_q, irq_v;

   assign wr_secs  = bus_we && (rtc_addr_e'(bus_addr) == RA_SECS);
   assign wr_alarm = bus_we && (rtc_addr_e'(bus_addr) == RA_ALARM);
   assign wr_stat  = bus_we && (rtc_addr_e'(bus_addr) == RA_STAT);
   assign wr_presc = bus_we && (rtc_addr_e'(bus_addr) == RA_PRESC);

   rtc_prescaler #(
      .DIV_W(DIV_W), .TRIM_W(TRIM_W), .TRIM_EN(TRIM_EN),
      .DIV_RESET(DIV_RESET), .TRIM_RESET(TRIM_RESET)
   ) u_presc (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load(wr_presc),
      .div_in(bus_wdata[DIV_W-1:0]),
      .trim_in(bus_wdata[TRIM_LSB +: TRIM_W]),
      .div_q(div_q), .trim_q(trim_q), .one_hz(one_hz)
   );

   rtc_seconds #(.CNT_W(CNT_W)) u_secs (
      .clk(clk), .rst_n(rst_n), .one_hz(one_hz),
      .wr_secs(wr_secs), .wr_alarm(wr_alarm), .wdata(bus_wdata),
      .secs_q(secs_q), .alarm_q(alarm_q), .match_evt(match_evt)
   );

   always_comb begin
      set_evt           = '0;
      set_evt[EV_ALARM] = match_evt;
      set_evt[EV_HZ]    = one_hz;
   end

   rtc_status #(.N(NUM_EV)) u_stat (
      .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .wr_stat(wr_stat),
      .clr_bits(bus_wdata[NUM_EV-1:0]),
      .en_bits(bus_wdata[EN_SHIFT +: NUM_EV]),
      .pend_q(pend_q), .en_q(en_q), .irq(irq_v)
   );

   assign irq_hz    = irq_v[EV_HZ];
   assign irq_alarm = irq_v[EV_ALARM];

   always_comb begin
      bus_rdata = '0;
      case (rtc_addr_e'(bus_addr))
         RA_SECS:  bus_rdata = secs_q;
         RA_ALARM: bus_rdata = alarm_q;
         RA_STAT: begin
            bus_rdata[NUM_EV-1:0]         = pend_q;
            bus_rdata[EN_SHIFT +: NUM_EV] = en_q;
         end
         default: begin
            bus_rdata[DIV_W-1:0]         = div_q;
            bus_rdata[TRIM_LSB +: TRIM_W] = trim_q;
         end
      endcase
   end
endmodule

// File: rtl/rtc_secs_alarm_chk.sv
`timescale 1ns/1ps
module rtc_secs_alarm_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             one_hz,
   input logic             wr_secs,
   input logic             wr_alarm,
   input logic             wr_stat,
   input logic [CNT_W-1:0] wdata,
   input logic [CNT_W-1:0] secs,
   input logic [1:0]       pend,
   input logic [1:0]       en,
   input logic             irq_hz,
   input logic             irq_alarm
);
   logic ev_any;
   assign ev_any = one_hz | wr_secs | wr_alarm;

   AST_SECS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (one_hz && !wr_secs) |=> secs == CNT_W'($past(secs) + 1'b1)); // R2
   AST_SECS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!one_hz && !wr_secs) |=> $stable(secs)); // R3
   AST_SECS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_secs |=> secs == $past(wdata)); // R3
   AST_HZ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      one_hz |=> pend[1]); // R4
   AST_ALM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend[0] && !$past(ev_any)) |=> !pend[0]); // R5
   AST_HZ_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wdata[1] && !one_hz) |=> !pend[1]); // R6
   AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat |=> en == $past(wdata[3:2])); // R7
   AST_IRQ_HZ_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hz |-> en[1]); // R8
   AST_IRQ_ALM_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_alarm |-> en[0]); // R8
endmodule

bind rtc_secs_alarm rtc_secs_alarm_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .one_hz(one_hz),
   .wr_secs(wr_secs), .wr_alarm(wr_alarm), .wr_stat(wr_stat),
   .wdata(bus_wdata), .secs(secs_q), .pend(pend_q), .en(en_q),
   .irq_hz(irq_hz), .irq_alarm(irq_alarm)
);

// File: tb/rtc_secs_alarm_bench.sv
`timescale 1ns/1ps
module rtc_secs_alarm_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_hz, irq_alarm;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   rtc_secs_alarm u_rtc_secs_alarm (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_hz(irq_hz), .irq_alarm(irq_alarm)
   );

   typedef struct {
      bit          is_irq;
      logic [1:0]  addr;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   // ---------------- driver ----------------
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      tick_en = 1'b0; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic expect_rd(input logic [1:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      tick_en = 1'b0; bus_we = 1'b0; bus_addr = a;
      it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
      sb.push_back(it);
   endtask

   // e[1] = irq_hz, e[0] = irq_alarm
   task automatic expect_irq(input logic [1:0] e, input string tag);
      item_t it;
      @(negedge clk);
      tick_en = 1'b0; bus_we = 1'b0;
      it.is_irq = 1'b1; it.addr = 2'd0; it.exp = {30'd0, e}; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic run(input int n);
      repeat (n) begin
         @(negedge clk);
         tick_en = 1'b1;
      end
      @(negedge clk);
      tick_en = 1'b0;
   endtask

   // ---------------- monitor ----------------
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            act = it.is_irq ? {30'd0, irq_hz, irq_alarm} : bus_rdata;
            total++;
            if (act !== it.exp) begin
               bad++;
               $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- scenarios ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      expect_rd(2'd0, 32'd0,     "R1 seconds");
      expect_rd(2'd1, 32'd0,     "R1 alarm");
      expect_rd(2'd2, 32'd0,     "R1 status");
      expect_rd(2'd3, 32'd32767, "R1 prescaler");
      expect_irq(2'b00,          "R1 irqs");

      // divide 3 -> period 4 ticks
      wr(2'd3, 32'h0000_0003);
      expect_rd(2'd3, 32'h0000_0003, "R10 prescaler readback");
      run(3);
      expect_rd(2'd0, 32'd0, "R2 before boundary");
      repeat (4) @(negedge clk);
      expect_rd(2'd0, 32'd0, "R2 idle ticks off");
      run(1);
      expect_rd(2'd0, 32'd1, "R2 first second");
      run(8);
      expect_rd(2'd0, 32'd3, "R2 two more seconds");
      expect_rd(2'd2, 32'h2, "R4 hz pending without enable");
      expect_irq(2'b00,      "R8 no irq when disabled");

      // write-one-to-clear
      wr(2'd2, 32'h1);
      expect_rd(2'd2, 32'h2, "R6 zero write keeps hz pending");
      wr(2'd2, 32'h2);
      expect_rd(2'd2, 32'h0, "R6 hz pending cleared");

      // enables and hz interrupt
      wr(2'd2, 32'h8);
      expect_rd(2'd2, 32'h8, "R7 hz enable readback");
      expect_irq(2'b00,      "R8 enable alone no irq");
      run(4);
      expect_rd(2'd2, 32'hA, "R4 hz pending with enable");
      expect_irq(2'b10,      "R8 hz irq");
      wr(2'd2, 32'hA);
      expect_rd(2'd2, 32'h8, "R6 clear keeps enable");
      expect_irq(2'b00,      "R8 hz irq dropped");

      // trim: divide 3, trim 2 -> period 6
      wr(2'd3, 32'h0002_0003);
      expect_rd(2'd3, 32'h0002_0003, "R10 trim readback");
      wr(2'd0, 32'd100);
      expect_rd(2'd0, 32'd100, "R3 counter load");
      run(5);
      expect_rd(2'd0, 32'd100, "R2 trim extends period");
      run(1);
      expect_rd(2'd0, 32'd101, "R2 trimmed second");
      expect_rd(2'd2, 32'hA, "R4 hz pending again");
      wr(2'd2, 32'h2);
      expect_rd(2'd2, 32'h0, "R7 enables cleared");

      // alarm by counting
      wr(2'd1, 32'd103);
      wr(2'd2, 32'h4);
      run(11);
      expect_rd(2'd2, 32'h6, "R5 no alarm before match");
      run(1);
      expect_rd(2'd0, 32'd103, "R2 counted to alarm");
      expect_rd(2'd2, 32'h7, "R5 alarm pending on match");
      expect_irq(2'b01,      "R8 alarm irq");

      // single shot while equal
      wr(2'd2, 32'h5);
      repeat (5) @(negedge clk);
      expect_rd(2'd2, 32'h6, "R5 no retrigger while equal");
      expect_irq(2'b00,      "R8 alarm irq cleared");
      wr(2'd1, 32'd103);
      expect_rd(2'd2, 32'h7, "R5 alarm write recompares");
      wr(2'd2, 32'h5);

      // alarm by counter write
      wr(2'd0, 32'd50);
      expect_rd(2'd2, 32'h6, "R5 mismatch write no alarm");
      wr(2'd0, 32'd103);
      expect_rd(2'd2, 32'h7, "R5 counter write match");
      wr(2'd2, 32'h7);
      expect_rd(2'd2, 32'h4, "R6 clear both keep alarm enable");

      // set wins over clear: divide 1 -> period 2
      wr(2'd3, 32'h0000_0001);
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b1; bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h2;
      @(negedge clk); tick_en = 1'b0; bus_we = 1'b0;
      expect_rd(2'd2, 32'h2, "R9 set beats clear");
      expect_rd(2'd0, 32'd104, "R2 short period");

      // counter write beats increment
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b1; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 32'd500;
      @(negedge clk); tick_en = 1'b0; bus_we = 1'b0;
      expect_rd(2'd0, 32'd500, "R3 write wins over increment");

      // wrap
      wr(2'd0, 32'hFFFF_FFFF);
      run(2);
      expect_rd(2'd0, 32'd0, "R11 wrap to zero");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule